// File: doc/BRIEF.md
# Card Command Issue and Response Capture Unit

This unit sits between a register bus and a memory-card command engine. Software first writes a 32-bit command argument as two 16-bit halves, then writes a command word. The unit splits that word into an index, a data direction, a command class and a response format. It then raises a request toward the card side, holding the command fields and a frozen copy of the argument until the card side acknowledges.

The acknowledgement carries up to sixteen response bytes and a byte count. In the same clock edge the unit stores the bytes into eight 16-bit response registers, in reversed halfword order. It also evaluates the response according to its format and updates a 16-bit event status register. The status bits are end of command, command timeout, operating-conditions ready and card error. An interrupt line is high whenever an enabled status bit is set. Software clears status bits by writing ones to them.

Top module: `sdcmd_engine`

## Requirements
- R1: The command word written at offset 0x00 drives the card outputs as follows: index from bits 5:0, response format from bits 10:8, command class from bits 13:12 and direction from bit 15. The argument is the low half written at 0x04 joined with the high half written at 0x08. Both halves read back at their offsets, and the accepted command word reads back at 0x00.
- R2: The request output rises in the cycle after a command write is accepted. It stays high, with index, format and argument unchanged (even if the argument registers are rewritten), up to and including the first edge where the acknowledge is high. It is low from the next cycle.
- R3: When the acknowledge arrives with a nonzero byte count, response register k, read at offset 0x40+4k, holds {byte 14-2k, byte 15-2k}, where byte i is card_data[8i+7:8i]. All sixteen bytes are stored regardless of the count.
- R4: For format 1, bytes 0..3 form a big-endian word. If that word shares any set bit with the card-error mask (default 0xFDF90000), status bit 14 is set; otherwise bit 14 is cleared.
- R5: For format 6, bytes 2 and 3 form a big-endian 16-bit word. If any of its bits 15:13 is set, status bit 14 is set; otherwise bit 14 is cleared.
- R6: For format 3, status bit 12 is set when bit 7 of byte 0 is clear, and left unchanged when it is set.
- R7: For any format other than 0, a zero byte count sets status bit 7 (timeout) and leaves bit 0, bit 14 and the response registers untouched. Every other completion, including any completion with format 0, sets status bit 0.
- R8: A write to status offset 0x10 clears exactly the bits written as one. If a completion lands on the same edge, its set bits take effect over the clear.
- R9: The interrupt-enable register at 0x14 keeps bits 14:0, and bit 15 reads as zero. The irq output is high exactly when status AND enable is nonzero.
- R10: An accepted command write clears all eight response registers.
- R11: A command write while the request is high is ignored. The card outputs, the command readback and the response registers all keep their values.
- R12: After reset, all registers read zero and both the request and irq outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| card_req | output | 1 | Command request pending |
| card_index | output | 6 | Command index |
| card_dir | output | 1 | Data direction |
| card_kind | output | 2 | Command class |
| card_rtype | output | 3 | Expected response format |
| card_arg | output | 32 | Command argument |
| card_ack | input | 1 | Card side completes the command |
| card_len | input | 5 | Number of response bytes returned |
| card_data | input | 128 | Response bytes, byte i at bits 8i+7:8i |
| irq | output | 1 | Interrupt request |

## Verification
A wrong busy flag shows up within one cycle, either as a request that never drops after the acknowledge or as a second command overwriting the first on the card outputs. A wrong response evaluation shows up in the status readback and on irq on the cycle right after the completion edge. A wrong byte ordering appears in the response registers at the same point. The unit has no hidden delay, so every fault becomes visible at the register bus no later than one cycle after the event that caused it.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // register byte offsets (fixed by the software view)
    localparam logic [7:0] OFF_CMD    = 8'h00;
    localparam logic [7:0] OFF_ARG_LO = 8'h04;
    localparam logic [7:0] OFF_ARG_HI = 8'h08;
    localparam logic [7:0] OFF_STAT   = 8'h10;
    localparam logic [7:0] OFF_IEN    = 8'h14;
    localparam logic [7:0] OFF_RSP    = 8'h40;

    // status bit positions
    localparam int ST_EOC  = 0;
    localparam int ST_CTO  = 7;
    localparam int ST_RDY  = 12;
    localparam int ST_CERR = 14;

    typedef enum logic [2:0] {
        RSP_NONE  = 3'd0,
        RSP_SHORT = 3'd1,
        RSP_LONG  = 3'd2,
        RSP_OCR   = 3'd3,
        RSP_ADDR  = 3'd6
    } rsp_kind_e;

    typedef struct packed {
        logic       dir;
        logic [1:0] kind;
        rsp_kind_e  rtype;
        logic [5:0] index;
    } cmd_fields_t;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic [15:0] word_i,
    output cmd_fields_t fld_o
);

    logic unused_bits;
    assign unused_bits = ^{word_i[14], word_i[11], word_i[7:6]};

    always_comb begin
        fld_o.index = word_i[5:0];
        fld_o.rtype = rsp_kind_e'(word_i[10:8]);
        fld_o.kind  = word_i[13:12];
        fld_o.dir   = word_i[15];
    end

endmodule

// File: rtl/sdcmd_rsp_eval.sv
module sdcmd_rsp_eval
    import sdcmd_pkg::*;
#(
    parameter int unsigned RSP_BYTES     = 16,
    parameter int unsigned LEN_W         = 5,
    parameter logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000,
    parameter logic [15:0] ADDR_ERR_MASK = 16'hE000
) (
    input  rsp_kind_e                          rtype_i,
    input  logic [LEN_W-1:0]                   len_i,
    input  logic [8*RSP_BYTES-1:0]             data_i,
    output logic                               eoc_o,
    output logic                               cto_o,
    output logic                               rdy_o,
    output logic                               err_upd_o,
    output logic                               err_o,
    output logic                               cap_o,
    output logic [RSP_BYTES/2-1:0][15:0]       hw_o
);

    localparam int unsigned NUM_HW = RSP_BYTES / 2;

    logic [31:0] word32;
    logic [15:0] word16;
    logic        empty;

    assign word32 = {data_i[7:0], data_i[15:8], data_i[23:16], data_i[31:24]};
    assign word16 = {data_i[23:16], data_i[31:24]};
    assign empty  = (len_i == '0);

    // halfword k takes the byte pair counted from the far end of the response
    for (genvar k = 0; k < NUM_HW; k++) begin : g_hw
        localparam int unsigned HI = 2 * (NUM_HW - 1 - k);
        assign hw_o[k] = {data_i[8*HI +: 8], data_i[8*(HI+1) +: 8]};
    end

    always_comb begin
        eoc_o     = 1'b0;
        cto_o     = 1'b0;
        rdy_o     = 1'b0;
        err_upd_o = 1'b0;
        err_o     = 1'b0;
        cap_o     = !empty;
        if (rtype_i == RSP_NONE) begin
            eoc_o = 1'b1;
        end else if (empty) begin
            cto_o = 1'b1;
        end else begin
            eoc_o = 1'b1;
            case (rtype_i)
                RSP_SHORT: begin
                    err_upd_o = 1'b1;
                    err_o     = |(word32 & CARD_ERR_MASK);
                end
                RSP_ADDR: begin
                    err_upd_o = 1'b1;
                    err_o     = |(word16 & ADDR_ERR_MASK);
                end
                RSP_OCR: begin
                    rdy_o = !word32[31];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_rdmux.sv
module sdcmd_rdmux
    import sdcmd_pkg::*;
#(
    parameter int unsigned NUM_HW = 8
) (
    input  logic [7:0]              addr_i,
    input  logic [15:0]             cmd_i,
    input  logic [31:0]             arg_i,
    input  logic [15:0]             status_i,
    input  logic [14:0]             ien_i,
    input  logic [NUM_HW-1:0][15:0] rsp_i,
    output logic [15:0]             rdata_o
);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFF_CMD:    rdata_o = cmd_i;
            OFF_ARG_LO: rdata_o = arg_i[15:0];
            OFF_ARG_HI: rdata_o = arg_i[31:16];
            OFF_STAT:   rdata_o = status_i;
            OFF_IEN:    rdata_o = {1'b0, ien_i};
            default: begin
                for (int k = 0; k < NUM_HW; k++) begin
                    if (addr_i == OFF_RSP + 8'(4 * k)) rdata_o = rsp_i[k];
                end
            end
        endcase
    end

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int unsigned RSP_BYTES     = 16,
    parameter logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000,
    parameter logic [15:0] ADDR_ERR_MASK = 16'hE000,
    localparam int unsigned NUM_HW       = RSP_BYTES / 2,
    localparam int unsigned LEN_W        = $clog2(RSP_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [7:0]             reg_addr,
    input  logic [15:0]            reg_wdata,
    output logic [15:0]            reg_rdata,
    output logic                   card_req,
    output logic [5:0]             card_index,
    output logic                   card_dir,
    output logic [1:0]             card_kind,
    output logic [2:0]             card_rtype,
    output logic [31:0]            card_arg,
    input  logic                   card_ack,
    input  logic [LEN_W-1:0]       card_len,
    input  logic [8*RSP_BYTES-1:0] card_data,
    output logic                   irq
);

    typedef struct packed {
        logic                    busy;
        logic [15:0]             cmd;
        logic [31:0]             arg;
        logic [31:0]             iss_arg;
        logic [15:0]             status;
        logic [14:0]             ien;
        logic [NUM_HW-1:0][15:0] rsp;
    } state_t;

    state_t s_d, s_q;

    cmd_fields_t             fld;
    logic                    done;
    logic                    ev_eoc, ev_cto, ev_rdy, ev_err_upd, ev_err, ev_cap;
    logic [NUM_HW-1:0][15:0] ev_hw;

    sdcmd_decode u_dec (
        .word_i (s_q.cmd),
        .fld_o  (fld)
    );

    sdcmd_rsp_eval #(
        .RSP_BYTES     (RSP_BYTES),
        .LEN_W         (LEN_W),
        .CARD_ERR_MASK (CARD_ERR_MASK),
        .ADDR_ERR_MASK (ADDR_ERR_MASK)
    ) u_eval (
        .rtype_i   (fld.rtype),
        .len_i     (card_len),
        .data_i    (card_data),
        .eoc_o     (ev_eoc),
        .cto_o     (ev_cto),
        .rdy_o     (ev_rdy),
        .err_upd_o (ev_err_upd),
        .err_o     (ev_err),
        .cap_o     (ev_cap),
        .hw_o      (ev_hw)
    );

    sdcmd_rdmux #(
        .NUM_HW (NUM_HW)
    ) u_rd (
        .addr_i   (reg_addr),
        .cmd_i    (s_q.cmd),
        .arg_i    (s_q.arg),
        .status_i (s_q.status),
        .ien_i    (s_q.ien),
        .rsp_i    (s_q.rsp),
        .rdata_o  (reg_rdata)
    );

    assign done = s_q.busy & card_ack;

    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            case (reg_addr)
                OFF_CMD: begin
                    if (!s_q.busy) begin
                        s_d.busy    = 1'b1;
                        s_d.cmd     = reg_wdata;
                        s_d.iss_arg = s_q.arg;
                        s_d.rsp     = '0;
                    end
                end
                OFF_ARG_LO: s_d.arg[15:0]  = reg_wdata;
                OFF_ARG_HI: s_d.arg[31:16] = reg_wdata;
                OFF_STAT:   s_d.status     = s_q.status & ~reg_wdata;
                OFF_IEN:    s_d.ien        = reg_wdata[14:0];
                default: ;
            endcase
        end
        // completion lands after the software clear, so new events survive it
        if (done) begin
            s_d.busy = 1'b0;
            if (ev_eoc)     s_d.status[ST_EOC]  = 1'b1;
            if (ev_cto)     s_d.status[ST_CTO]  = 1'b1;
            if (ev_rdy)     s_d.status[ST_RDY]  = 1'b1;
            if (ev_err_upd) s_d.status[ST_CERR] = ev_err;
            if (ev_cap)     s_d.rsp             = ev_hw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign card_req   = s_q.busy;
    assign card_index = fld.index;
    assign card_dir   = fld.dir;
    assign card_kind  = fld.kind;
    assign card_rtype = fld.rtype;
    assign card_arg   = s_q.iss_arg;
    assign irq        = |(s_q.status[14:0] & s_q.ien);

endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk
    import sdcmd_pkg::*;
#(
    parameter int unsigned NUM_HW = 8,
    parameter int unsigned LEN_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [7:0]         reg_addr,
    input logic [15:0]        reg_wdata,
    input logic               card_req,
    input logic               card_ack,
    input logic [5:0]         card_index,
    input logic [2:0]         card_rtype,
    input logic [31:0]        card_arg,
    input logic [LEN_W-1:0]   card_len,
    input logic               irq,
    input logic [15:0]        status,
    input logic [14:0]        ien,
    input logic [16*NUM_HW-1:0] rsp
);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && !card_ack |=> card_req && $stable(card_arg)
                                  && $stable(card_index) && $stable(card_rtype));

    p_req_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && card_ack |=> !card_req);

    p_rsp_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFF_CMD && !card_req |=> card_req && rsp == '0);

    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFF_CMD && card_req && !card_ack |=> $stable(rsp));

    p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && card_ack && card_len == '0 && card_rtype != 3'd0
            |=> status[ST_CTO] && rsp == '0);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFF_STAT && !(card_req && card_ack)
            |=> (status & $past(reg_wdata)) == '0);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ien == '0 |-> !irq);

endmodule

bind sdcmd_engine sdcmd_engine_chk #(
    .NUM_HW (NUM_HW),
    .LEN_W  (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .card_req   (card_req),
    .card_ack   (card_ack),
    .card_index (card_index),
    .card_rtype (card_rtype),
    .card_arg   (card_arg),
    .card_len   (card_len),
    .irq        (irq),
    .status     (s_q.status),
    .ien        (s_q.ien),
    .rsp        (s_q.rsp)
);

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ERRM = 32'hFDF9_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         card_req;
    logic [5:0]   card_index;
    logic         card_dir;
    logic [1:0]   card_kind;
    logic [2:0]   card_rtype;
    logic [31:0]  card_arg;
    logic         card_ack = 1'b0;
    logic [4:0]   card_len = '0;
    logic [127:0] card_data = '0;
    logic         irq;

    int total = 0;
    int bad   = 0;

    logic [15:0] m_st;
    logic [14:0] m_ien;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcmd_engine u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .card_req (card_req),
        .card_index (card_index), .card_dir (card_dir), .card_kind (card_kind),
        .card_rtype (card_rtype), .card_arg (card_arg), .card_ack (card_ack),
        .card_len (card_len), .card_data (card_data), .irq (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic respond(input logic [4:0] len, input logic [127:0] data);
        card_ack = 1'b1; card_len = len; card_data = data;
        @(negedge clk);
        card_ack = 1'b0;
    endtask

    function automatic logic [7:0] byt(input logic [127:0] d, input int i);
        return d[8*i +: 8];
    endfunction

    function automatic logic [15:0] exp_status(input logic [15:0] old, input logic [2:0] rt,
                                               input logic [4:0] len, input logic [127:0] d);
        logic [15:0] s;
        logic [31:0] w;
        s = old;
        w = {byt(d,0), byt(d,1), byt(d,2), byt(d,3)};
        if (rt == 3'd0) s[0] = 1'b1;
        else if (len == 0) s[7] = 1'b1;
        else begin
            s[0] = 1'b1;
            if (rt == 3'd1) s[14] = |(w & ERRM);
            if (rt == 3'd6) s[14] = |w[15:13];
            if (rt == 3'd3 && !w[31]) s[12] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [15:0] exp_rsp(input int k, input logic [4:0] len, input logic [127:0] d);
        if (len == 0) return 16'h0;
        return {byt(d, 14 - 2*k), byt(d, 15 - 2*k)};
    endfunction

    task automatic check_rsp(input string tag, input logic [4:0] len, input logic [127:0] d);
        logic [15:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(8'h40 + 8'(4*k), v);
            chk(tag, v, exp_rsp(k, len, d));
        end
    endtask

    // full command cycle with model update and checks
    task automatic run_cmd(input string tag, input logic [15:0] cw, input logic [4:0] len,
                           input logic [127:0] d);
        logic [15:0] v;
        wr(8'h00, cw);
        chk("R2 req raised", card_req, 1'b1);
        chk("R1 index", card_index, cw[5:0]);
        chk("R1 rtype", card_rtype, cw[10:8]);
        chk("R1 kind", card_kind, cw[13:12]);
        chk("R1 dir", card_dir, cw[15]);
        respond(len, d);
        chk("R2 req dropped", card_req, 1'b0);
        m_st = exp_status(m_st, cw[10:8], len, d);
        rd(8'h10, v);
        chk(tag, v, m_st);
        chk("R9 irq", irq, |(m_st[14:0] & m_ien));
        check_rsp("R3 rsp regs", len, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0]  v;
        logic [127:0] d;
        m_st = '0; m_ien = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        chk("R12 req", card_req, 1'b0);
        chk("R12 irq", irq, 1'b0);
        rd(8'h10, v); chk("R12 status", v, 16'h0);
        rd(8'h14, v); chk("R12 ien", v, 16'h0);
        rd(8'h00, v); chk("R12 cmd", v, 16'h0);
        rd(8'h40, v); chk("R12 rsp0", v, 16'h0);

        // R1 argument halves and field mapping
        wr(8'h04, 16'h1234);
        wr(8'h08, 16'hABCD);
        rd(8'h04, v); chk("R1 arg lo", v, 16'h1234);
        rd(8'h08, v); chk("R1 arg hi", v, 16'hABCD);
        wr(8'h00, 16'hA111);
        chk("R2 req", card_req, 1'b1);
        chk("R1 index", card_index, 6'd17);
        chk("R1 rtype", card_rtype, 3'd1);
        chk("R1 kind", card_kind, 2'd2);
        chk("R1 dir", card_dir, 1'b1);
        chk("R1 arg", card_arg, 32'hABCD1234);
        // R2 argument frozen while pending
        wr(8'h04, 16'h5555);
        chk("R2 arg frozen", card_arg, 32'hABCD1234);
        repeat (3) @(negedge clk);
        chk("R2 req held", card_req, 1'b1);
        // R11 second command ignored
        wr(8'h00, 16'h0305);
        chk("R11 index kept", card_index, 6'd17);
        chk("R11 rtype kept", card_rtype, 3'd1);
        rd(8'h00, v); chk("R11 cmd readback", v, 16'hA111);
        rd(8'h40, v); chk("R11 rsp untouched", v, 16'h0);
        d = 128'h0F0E_0D0C_0B0A_0908_0706_0504_0009_0000;
        respond(5'd6, d);
        chk("R2 req dropped", card_req, 1'b0);
        m_st = exp_status(m_st, 3'd1, 5'd6, d);
        rd(8'h10, v); chk("R4 no error", v, 16'h0001);
        rd(8'h5C, v); chk("R3 rsp7", v, 16'h0000);
        rd(8'h58, v); chk("R3 rsp6", v, 16'h0900);
        rd(8'h40, v); chk("R3 rsp0", v, 16'h0E0F);

        // R9 enable register and irq
        chk("R9 irq masked", irq, 1'b0);
        wr(8'h14, 16'hFFFF); m_ien = 15'h7FFF;
        rd(8'h14, v); chk("R9 ien bit15", v, 16'h7FFF);
        chk("R9 irq on", irq, 1'b1);
        // R8 clear by ones
        wr(8'h10, 16'h0001); m_st = '0;
        rd(8'h10, v); chk("R8 cleared", v, 16'h0);
        chk("R9 irq off", irq, 1'b0);

        // R4 error bit set, then R10 wipe on new command
        run_cmd("R4 error set", 16'h0101, 5'd6, 128'hFFFF_0000_0000_0000_0000_0000_0000_0080);
        wr(8'h00, 16'h0202);
        rd(8'h40, v); chk("R10 rsp0 wiped", v, 16'h0);
        rd(8'h5C, v); chk("R10 rsp7 wiped", v, 16'h0);
        // R7 timeout: bit 7 set, bit 0 untouched
        wr(8'h10, 16'hFFFF); m_st = '0;
        respond(5'd0, 128'h1);
        m_st = exp_status(m_st, 3'd2, 5'd0, 128'h1);
        rd(8'h10, v); chk("R7 timeout", v, 16'h0080);
        check_rsp("R7 rsp stay zero", 5'd0, '0);

        // R8 clear and completion on the same edge
        wr(8'h00, 16'h0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 16'hFFFF;
        card_ack = 1'b1; card_len = 5'd0;
        @(negedge clk);
        reg_wr = 1'b0; card_ack = 1'b0;
        m_st = 16'h0001;
        rd(8'h10, v); chk("R8 set wins", v, 16'h0001);

        // R6 operating-conditions format
        wr(8'h10, 16'hFFFF); m_st = '0;
        run_cmd("R6 ready set", 16'h0329, 5'd6, 128'h0000_00FF_FF00);
        wr(8'h10, 16'hFFFF); m_st = '0;
        run_cmd("R6 busy keeps", 16'h0329, 5'd6, 128'h0000_00FF_FF80);
        rd(8'h10, v); chk("R6 bit12 clear", v[12], 1'b0);

        // R5 published-address format
        run_cmd("R5 error set", 16'h0603, 5'd6, 128'h0000_0000_0020_0000);
        run_cmd("R5 error cleared", 16'h0603, 5'd6, 128'h0000_0000_001F_0000);
        rd(8'h10, v); chk("R5 bit14 low", v[14], 1'b0);

        // random mix
        void'($urandom(32'd2024));
        for (int it = 0; it < 60; it++) begin
            logic [2:0]  rt;
            logic [4:0]  ln;
            logic [15:0] cw;
            logic [15:0] cm;
            case ($urandom % 5)
                0: rt = 3'd0; 1: rt = 3'd1; 2: rt = 3'd2; 3: rt = 3'd3; default: rt = 3'd6;
            endcase
            ln = ($urandom % 4 == 0) ? 5'd0 : 5'(1 + $urandom % 16);
            d  = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom % 2 == 0) d[31:0] = d[31:0] & 32'h0206_FFFF;
            cw = {1'($urandom), 2'b00, 2'($urandom), 1'b0, rt, 2'b00, 6'($urandom)};
            if ($urandom % 3 == 0) begin
                cm = 16'($urandom);
                wr(8'h10, cm);
                m_st = m_st & ~cm;
            end
            if ($urandom % 4 == 0) begin
                m_ien = 15'($urandom);
                wr(8'h14, {1'b0, m_ien});
            end
            run_cmd("R4 R5 R6 R7 random status", cw, ln, d);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule